// File: doc/BRIEF.md
# Generator-Store Block Address Recorder and Push Sequencer

This block sits beside one core and keeps a short list of the cache lines that its flagged producer stores have written during the current code segment. Every committed store arrives with its physical address and a flag saying whether it is a generator store. Only flagged stores are kept. The block reduces each address to its 64-byte line number and keeps each line once.

When the segment hands off, a transfer command names the core that runs the next segment. The block then emits one push request per recorded line, each carrying the line number and that destination core. The requests leave in the order the lines were first recorded and use a valid/ready handshake. A critical-section call also empties the list, always toward the fixed accelerator core. When the last request is accepted the list is empty and recording starts again. The downstream cache fill and the network that carries the requests are outside this block.

The control is a two-state machine. In `ST_IDLE` the block records stores and waits for a command. The transition *start* (a command while the list, counting any store recorded in that same cycle, is non-empty) leads to `ST_DRAIN`. A command that finds the list empty takes the transition *skip* and stays in `ST_IDLE`. In `ST_DRAIN` one request is offered per cycle. The transition *advance* (accepted, not last) stays in `ST_DRAIN`. The transition *finish* (last request accepted) clears the list and returns to `ST_IDLE`.

Top module: `marshal_addr_buf`

## Requirements
- R1: After reset the list is empty, `push_valid` is 0, `busy` is 0 and `overflow` is 0.
- R2: A store with `st_gen` low is never recorded and never produces a push request.
- R3: A recorded line is `st_addr[ADDR_W-1:6]`. Address bit 0 to bit 5 are ignored, so two stores inside one 64-byte line are the same line, and `push_blk` carries the line number.
- R4: A generator store to a line already in the list adds no second entry.
- R5: The list holds 16 lines. A generator store to a new line while 16 are held is dropped, and `overflow` reads 1 from the next cycle. `overflow` returns to 0 when a drain command is accepted, unless a store is dropped in that same cycle.
- R6: A transfer command (`xfer_valid`) drains the list toward `xfer_dest`. Requests come out in first-recorded order, at most one per cycle, and each carries `xfer_dest` in `push_dest`.
- R7: A critical-section call (`cs_call`) drains the list toward the core given by parameter `ACCEL_ID` (default 12). When `xfer_valid` and `cs_call` arrive together, the transfer command's destination is used.
- R8: While `push_valid` is 1 and `push_ready` is 0, `push_valid`, `push_blk` and `push_dest` hold their values into the next cycle.
- R9: Once the last request is accepted, `push_valid` and `busy` drop in the next cycle and the list is empty. A line drained earlier can be recorded again.
- R10: While `busy` is 1, incoming stores and commands have no effect.
- R11: A command that finds the list empty produces no request and leaves `busy` at 0.
- R12: A generator store recorded in the same cycle as an accepted command is included in that drain, as its last request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | A store committed this cycle |
| st_gen | input | 1 | That store is a generator store |
| st_addr | input | ADDR_W | Physical store address |
| xfer_valid | input | 1 | Segment-transfer command |
| xfer_dest | input | CORE_W | Destination core of the transfer command |
| cs_call | input | 1 | Critical-section call, which drains toward `ACCEL_ID` |
| push_ready | input | 1 | Receiver accepts the current request |
| push_valid | output | 1 | A push request is offered |
| push_blk | output | ADDR_W-6 | Line number of the request |
| push_dest | output | CORE_W | Destination core of the request |
| busy | output | 1 | Drain in progress |
| overflow | output | 1 | A generator store was dropped because the list was full |

## Verification
The assertions check the rules that hold on every cycle:
- the entry count never exceeds the depth, and nothing is written into a full list;
- a write never duplicates a line already held;
- a stalled request holds steady;
- the read index steps by one per accepted request;
- the machine leaves `ST_DRAIN` right after the last acceptance;
- a drop raises `overflow`;
- stores cannot change the count during a drain.

Only the bench scenarios can show the rest, because it needs the full contents of a drain compared with the recorded history. This covers the first-recorded order, line merging within 64 bytes, the destination chosen for each kind of command, stores ignored during a drain, and a store that lands on the same cycle as the command.

// File: rtl/mab_pkg.sv
package mab_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_DRAIN = 1'b1
    } mab_state_e;
endpackage

// File: rtl/mab_line_store.sv
module mab_line_store #(
    parameter int DEPTH = 16,
    parameter int BLK_W = 34,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BLK_W-1:0] wr_blk,
    input  logic             clr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [BLK_W-1:0] rd_blk,
    output logic             hit,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    logic [BLK_W-1:0] slot [DEPTH];
    logic [DEPTH-1:0] match;

    // one comparator per slot, qualified by occupancy
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = (CNT_W'(g) < count) && (slot[g] == wr_blk);
    end

    assign hit    = |match;
    assign full   = (count == CNT_W'(DEPTH));
    assign rd_blk = slot[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (clr)   count <= '0;
        else if (wr_en) count <= count + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (wr_en) slot[count[IDX_W-1:0]] <= wr_blk;
    end

    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    a_r5_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    a_r4_no_dup_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !hit);
endmodule

// File: rtl/mab_drain_fsm.sv
module mab_drain_fsm
    import mab_pkg::*;
#(
    parameter int CORE_W   = 4,
    parameter int IDX_W    = 4,
    parameter int CNT_W    = 5,
    parameter int ACCEL_ID = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_valid,
    input  logic [CORE_W-1:0] xfer_dest,
    input  logic              cs_call,
    input  logic              rec_fire,
    input  logic [CNT_W-1:0]  count,
    input  logic              push_ready,
    output logic              push_valid,
    output logic [CORE_W-1:0] push_dest,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              clr,
    output logic              busy
);
    mab_state_e        state, state_nx;
    logic [IDX_W-1:0]  ptr;
    logic [CORE_W-1:0] dest;
    logic              cmd, last, fire;

    assign cmd  = xfer_valid | cs_call;
    assign fire = (state == ST_DRAIN) && push_ready;
    assign last = (CNT_W'(ptr) == count - CNT_W'(1));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cmd && (count != '0 || rec_fire)) state_nx = ST_DRAIN; // start
            ST_DRAIN: if (fire && last)                     state_nx = ST_IDLE;  // finish
            default:                                        state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ptr   <= '0;
            dest  <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE) begin
                ptr <= '0;
                if (cmd) dest <= xfer_valid ? xfer_dest : CORE_W'(ACCEL_ID);
            end else if (fire && !last) begin
                ptr <= ptr + IDX_W'(1);
            end
        end
    end

    always_comb begin
        push_valid = 1'b0;
        busy       = 1'b0;
        clr        = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_DRAIN: begin
                push_valid = 1'b1;
                busy       = 1'b1;
                clr        = fire && last;
            end
            default: ;
        endcase
        push_dest = dest;
        rd_idx    = ptr;
    end

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && !push_ready |=> push_valid && $stable(push_dest) && $stable(rd_idx));
    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !last |=> rd_idx == $past(rd_idx) + IDX_W'(1));
    a_r9_stop: assert property (@(posedge clk) disable iff (!rst_n)
        fire && last |=> !push_valid);
endmodule

// File: rtl/marshal_addr_buf.sv
module marshal_addr_buf #(
    parameter int ADDR_W    = 40,
    parameter int LINE_BITS = 6,
    parameter int DEPTH     = 16,
    parameter int CORE_W    = 4,
    parameter int ACCEL_ID  = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        st_valid,
    input  logic                        st_gen,
    input  logic [ADDR_W-1:0]           st_addr,
    input  logic                        xfer_valid,
    input  logic [CORE_W-1:0]           xfer_dest,
    input  logic                        cs_call,
    input  logic                        push_ready,
    output logic                        push_valid,
    output logic [ADDR_W-LINE_BITS-1:0] push_blk,
    output logic [CORE_W-1:0]           push_dest,
    output logic                        busy,
    output logic                        overflow
);
    localparam int BLK_W = ADDR_W - LINE_BITS;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [BLK_W-1:0] st_blk;
    logic             hit, full, clr, accept, rec_fire, drop, cmd_take;
    logic [CNT_W-1:0] count;
    logic [IDX_W-1:0] rd_idx;

    assign st_blk   = st_addr[ADDR_W-1:LINE_BITS];
    assign accept   = st_valid && st_gen && !busy;
    assign rec_fire = accept && !hit && !full;
    assign drop     = accept && !hit && full;
    assign cmd_take = !busy && (xfer_valid || cs_call);

    mab_line_store #(.DEPTH(DEPTH), .BLK_W(BLK_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(rec_fire), .wr_blk(st_blk), .clr(clr),
        .rd_idx(rd_idx), .rd_blk(push_blk), .hit(hit), .full(full), .count(count)
    );

    mab_drain_fsm #(.CORE_W(CORE_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .ACCEL_ID(ACCEL_ID)) u_fsm (
        .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_dest(xfer_dest),
        .cs_call(cs_call), .rec_fire(rec_fire), .count(count), .push_ready(push_ready),
        .push_valid(push_valid), .push_dest(push_dest), .rd_idx(rd_idx), .clr(clr), .busy(busy)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        overflow <= 1'b0;
        else if (drop)     overflow <= 1'b1;
        else if (cmd_take) overflow <= 1'b0;
    end

    a_r5_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> overflow);
    a_r10_frozen_count: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !clr |=> $stable(count));
endmodule

// File: tb/marshal_addr_buf_bench.sv
module marshal_addr_buf_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 0, st_gen = 0, xfer_valid = 0, cs_call = 0, push_ready = 1;
    logic [39:0] st_addr = '0;
    logic [3:0]  xfer_dest = '0;
    logic        push_valid, busy, overflow;
    logic [33:0] push_blk;
    logic [3:0]  push_dest;

    int n_chk = 0, n_fail = 0;
    logic [37:0] expq [$];   // {dest, blk}
    logic [33:0] mbuf [$];
    logic        m_ovf = 0;
    bit          toggle_rdy = 0;
    bit          held = 0;
    logic [37:0] held_v;

    always #10 clk = ~clk;   // 50 MHz

    marshal_addr_buf u_marshal_addr_buf (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_gen(st_gen), .st_addr(st_addr),
        .xfer_valid(xfer_valid), .xfer_dest(xfer_dest), .cs_call(cs_call),
        .push_ready(push_ready), .push_valid(push_valid), .push_blk(push_blk),
        .push_dest(push_dest), .busy(busy), .overflow(overflow)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    always @(posedge clk) begin
        #2;
        if (toggle_rdy) push_ready = ~push_ready;
        else            push_ready = 1'b1;
    end

    // monitor: scoreboard compare and stall-hold check (R6, R7, R8)
    always @(negedge clk) begin
        if (rst_n) begin
            if (held) begin
                check(push_valid && {push_dest, push_blk} == held_v, "R8 hold",
                      {push_valid, push_dest, push_blk}, {1'b1, held_v});
                held = 0;
            end
            if (push_valid && push_ready) begin
                if (expq.size() == 0) begin
                    check(0, "R6 unexpected push", {push_dest, push_blk}, 0);
                end else begin
                    logic [37:0] e;
                    e = expq.pop_front();
                    check({push_dest, push_blk} == e, "R6/R7 push", {push_dest, push_blk}, e);
                end
            end else if (push_valid) begin
                held = 1;
                held_v = {push_dest, push_blk};
            end
        end
    end

    function automatic void model_store(input logic [39:0] a);
        logic [33:0] b;
        b = a[39:6];
        foreach (mbuf[i]) if (mbuf[i] == b) return;
        if (mbuf.size() == 16) m_ovf = 1;
        else mbuf.push_back(b);
    endfunction

    function automatic void model_drain(input logic [3:0] d);
        foreach (mbuf[i]) expq.push_back({d, mbuf[i]});
        mbuf.delete();
        m_ovf = 0;
    endfunction

    task automatic do_store(input logic [39:0] a, input bit g);
        st_valid = 1; st_gen = g; st_addr = a;
        if (g) model_store(a);
        tick();
        st_valid = 0; st_gen = 0;
    endtask

    task automatic do_cmd(input bit x, input bit c, input logic [3:0] d);
        xfer_valid = x; cs_call = c; xfer_dest = d;
        model_drain(x ? d : 4'd12);
        tick();
        xfer_valid = 0; cs_call = 0;
    endtask

    task automatic wait_done(input string req);
        for (int k = 0; k < 200 && busy; k++) tick();
        tick();
        check(!busy && expq.size() == 0, req, {busy, 32'(expq.size())}, 0);
    endtask

    initial begin
        #(20 * 100000);
        check(0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1;
        #5;
        check(!push_valid && !busy && !overflow, "R1 reset", {push_valid, busy, overflow}, 0);
        tick();

        // R2, R6: generator vs plain stores, drain to core 5
        do_store(40'h10_0000_0040, 1);
        do_store(40'h10_0000_0080, 0);
        do_store(40'h10_0000_1000, 1);
        do_store(40'h22_0000_0000, 1);
        do_store(40'h33_0000_0000, 0);
        do_cmd(1, 0, 4'd5);
        wait_done("R2 R6 drain complete");

        // R3, R4, R8: same line merge, duplicate, stalled ready
        toggle_rdy = 1;
        do_store(40'h01_2345_6700, 1);
        do_store(40'h01_2345_673F, 1);
        do_store(40'h01_0000_0000, 1);
        do_store(40'h01_2345_6710, 1);
        do_cmd(1, 0, 4'd3);
        wait_done("R3 R4 R8 merged drain");
        toggle_rdy = 0;

        // R11: empty list
        do_cmd(1, 0, 4'd7);
        check(!busy && !push_valid, "R11 empty command", {busy, push_valid}, 0);
        tick();

        // R5, R7: overflow then critical-section drain toward ACCEL_ID
        for (int i = 0; i < 17; i++) do_store(40'h40_0000_0000 + 40'(i * 64), 1);
        #5;
        check(overflow == 1'b1, "R5 overflow set", overflow, 1);
        do_cmd(0, 1, 4'd0);
        #5;
        check(overflow == 1'b0, "R5 overflow cleared", overflow, 0);
        wait_done("R5 R7 sixteen pushes");

        // R10: store and command during drain are ignored
        do_store(40'h50_0000_0000, 1);
        do_store(40'h50_0000_0040, 1);
        do_store(40'h50_0000_0080, 1);
        do_cmd(1, 0, 4'd9);
        st_valid = 1; st_gen = 1; st_addr = 40'h66_0000_0000;
        xfer_valid = 1; xfer_dest = 4'd2;
        tick();
        st_valid = 0; st_gen = 0; xfer_valid = 0;
        wait_done("R10 drain unaffected");
        do_cmd(1, 0, 4'd2);
        check(!busy, "R10 store during drain not kept", busy, 0);
        tick();

        // R12: store in same cycle as command is drained last
        do_store(40'h70_0000_0000, 1);
        st_valid = 1; st_gen = 1; st_addr = 40'h71_0000_0000;
        model_store(40'h71_0000_0000);
        do_cmd(1, 0, 4'd4);
        st_valid = 0; st_gen = 0;
        wait_done("R12 same-cycle store");

        // R7 priority, R9 line drained earlier recorded again
        do_store(40'h70_0000_0000, 1);
        do_cmd(1, 1, 4'd6);
        wait_done("R7 transfer wins, R9 re-record");
        check(!push_valid && !busy, "R9 empty after drain", {push_valid, busy}, 0);

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule